// File: doc/BRIEF.md
# Receive DMA Burst Write Engine

This block moves received packet bytes from a local byte FIFO into system memory. It issues write requests toward a bus master port. Packet bytes enter one per cycle on a valid/ready port, and a flag marks the last byte of a packet. A start pulse with a destination address arms the engine for one packet. The engine then keeps the buffer address, counts the bytes it has written and ends with a done pulse that carries the packet's byte count.

The engine chooses each access from the FIFO fill level and the current address. While the address is not word-aligned it writes single bytes. Once aligned, it writes 32-bit word bursts whose length is half the FIFO depth in words, but only when the FIFO holds at least half its capacity. After the packet's last byte has entered the FIFO, the threshold no longer applies: the final burst takes whatever whole words remain, and one to three trailing bytes go out as single-byte writes.

Each access keeps the request line high until the bus master has acknowledged every beat. The address output always shows the address of the current beat, and the request line drops for at least one cycle before the next access. Only one packet end can wait in the FIFO at a time, so the input stalls after a last byte until the engine has drained it.

Top module: `rxdma_burst_writer`

## Requirements
- R1: When the packet's last byte is not yet in the FIFO, a word burst starts only if the fill level is at least FIFO_WORDS*2 bytes; otherwise the engine waits with the request line low.
- R2: A word burst (size code 2) that is not the packet's last word burst has a length of exactly FIFO_WORDS/2 beats.
- R3: Once the packet's last byte is in the FIFO, an aligned access with four or more bytes left is a word burst of min(level/4, FIFO_WORDS/2) beats. This final burst may therefore be shorter.
- R4: While the address bits [1:0] are nonzero, the engine issues single-byte writes (size code 0, length 1), so word bursts always start word-aligned.
- R5: When fewer than four bytes of an ended packet remain at an aligned address, each remaining byte is written as a single-byte access.
- R6: The beat address starts at the start address, then rises by 1 after each acknowledged byte beat and by 4 after each acknowledged word beat.
- R7: A byte write places the byte in data bits [8*a+7:8*a], where a = address bits [1:0], and the other bits are zero. A word beat carries the oldest FIFO byte in bits [7:0] and the next bytes in ascending lanes.
- R8: The request line goes low for at least one cycle after the last acknowledged beat of each access. An acknowledge while the request line is low has no effect.
- R9: One cycle after the beat that carries the packet's last byte is acknowledged, done is high for exactly one cycle and reports the packet's total byte count.
- R10: in_ready is low while the FIFO is full or while a last byte waits in it. After reset in_ready is high and the request line and done are low, and a start pulse while a packet is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Packet byte present |
| in_data | input | 8 | Packet byte |
| in_last | input | 1 | Byte is the last of its packet |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| start | input | 1 | Arms the engine for one packet (ignored while busy) |
| start_addr | input | ADDR_W | Buffer byte address for the packet |
| wr_req | output | 1 | Write access in progress |
| wr_addr | output | ADDR_W | Address of the current beat |
| wr_size | output | 2 | 0 = byte, 2 = 32-bit word |
| wr_len | output | LEN_W | Beats in this access |
| wr_data | output | 32 | Data of the current beat |
| wr_ack | input | 1 | Current beat accepted by the bus master |
| done | output | 1 | One-cycle packet-complete pulse |
| done_bytes | output | CNT_W | Bytes written for the packet, valid with done |

## Verification
On every cycle, the assertions check the local rules: word bursts are aligned and never longer than half the FIFO; a short word burst happens only after the packet has ended; a burst that begins before the end follows a fill level at or above the threshold; the address steps correctly between beats; the request line drops after a final beat; done lasts one cycle; and the FIFO is never read beyond its level. The bench's scenarios show the end-to-end results. These include the number of head and tail byte writes for each alignment and length, the lane placement of data, and the held-off burst while the level sits one byte below the threshold. They also cover byte totals under slow input and stalled acknowledges, and that a start pulse during a packet is ignored.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECIDE = 2'd1,
        ST_ISSUE  = 2'd2,
        ST_DONE   = 2'd3
    } rxdma_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam int unsigned LANES = 4;

endpackage

// File: rtl/rxdma_byte_fifo.sv
module rxdma_byte_fifo #(
    parameter int unsigned FIFO_WORDS = 8,
    localparam int unsigned DEPTH = FIFO_WORDS * 4,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid_i,
    input  logic [7:0]       in_data_i,
    input  logic             in_last_i,
    output logic             in_ready_o,
    input  logic             pop_byte_i,
    input  logic             pop_word_i,
    output logic [LVL_W-1:0] level_o,
    output logic             eop_held_o,
    output logic [31:0]      peek_data_o,
    output logic [3:0]       peek_last_o
);
    import rxdma_pkg::*;

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [LVL_W-1:0] level;
        logic             eop_held;
    } fifo_s;

    fifo_s q, n;
    logic [8:0] mem_q [DEPTH];
    logic push;
    logic [LVL_W-1:0] pop_n;
    logic popped_last;

    for (genvar k = 0; k < LANES; k++) begin : g_peek
        logic [PTR_W-1:0] idx;
        assign idx = q.rptr + PTR_W'(k);
        assign peek_data_o[8*k +: 8] = mem_q[idx][7:0];
        assign peek_last_o[k]        = mem_q[idx][8];
    end

    assign in_ready_o = (q.level < LVL_W'(DEPTH)) && !q.eop_held;
    assign level_o    = q.level;
    assign eop_held_o = q.eop_held;

    always_comb begin
        n           = q;
        push        = in_valid_i && in_ready_o;
        pop_n       = pop_word_i ? LVL_W'(4) : (pop_byte_i ? LVL_W'(1) : '0);
        popped_last = (pop_byte_i && peek_last_o[0]) || (pop_word_i && (|peek_last_o));
        n.rptr      = q.rptr + PTR_W'(pop_n);
        n.level     = q.level - pop_n;
        if (popped_last) begin
            n.eop_held = 1'b0;
        end
        if (push) begin
            n.wptr  = q.wptr + PTR_W'(1);
            n.level = n.level + LVL_W'(1);
            if (in_last_i) begin
                n.eop_held = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[q.wptr] <= {in_last_i, in_data_i};
        end
    end

    // R3: a word read never reaches past the stored bytes
    p_pop_avail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_word_i |-> (q.level >= LVL_W'(4)));

    // R5: a byte read needs at least one stored byte
    p_byte_avail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_byte_i |-> (q.level != '0));

    // R10: level stays within capacity
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.level <= LVL_W'(DEPTH));

    // R10: a held packet end stays until it is read out
    p_eop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.eop_held && !pop_byte_i && !pop_word_i) |=> q.eop_held);

endmodule

// File: rtl/rxdma_lane_pack.sv
module rxdma_lane_pack (
    input  logic [31:0] peek_data_i,
    input  logic [1:0]  size_i,
    input  logic [1:0]  lane_i,
    output logic [31:0] data_o
);
    import rxdma_pkg::*;

    always_comb begin
        if (size_i == SZ_WORD) begin
            data_o = peek_data_i;
        end else begin
            data_o = {24'd0, peek_data_i[7:0]} << {lane_i, 3'b000};
        end
    end

endmodule

// File: rtl/rxdma_xfer_ctrl.sv
module rxdma_xfer_ctrl #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned FIFO_WORDS = 8,
    localparam int unsigned DEPTH  = FIFO_WORDS * 4,
    localparam int unsigned LVL_W  = $clog2(DEPTH + 1),
    localparam int unsigned HALF   = FIFO_WORDS / 2,
    localparam int unsigned LEN_W  = $clog2(HALF + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              ack_i,
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic              eop_held_i,
    input  logic [3:0]        peek_last_i,
    output logic              pop_byte_o,
    output logic              pop_word_o,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        size_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  done_bytes_o
);
    import rxdma_pkg::*;

    localparam logic [LVL_W-1:0] HALF_BYTES = LVL_W'(HALF * 4);
    localparam logic [LVL_W-1:0] HALF_WORDS = LVL_W'(HALF);

    typedef struct packed {
        rxdma_state_e      state;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  bytes;
        logic [1:0]        size;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  beats;
        logic              pkt_end;
    } ctrl_s;

    ctrl_s q, n;
    logic [LVL_W-1:0] words_avail;
    logic [LEN_W-1:0] tail_len;

    assign words_avail = lvl_i >> 2;
    assign tail_len    = (words_avail >= HALF_WORDS) ? LEN_W'(HALF) : words_avail[LEN_W-1:0];

    always_comb begin
        n          = q;
        pop_byte_o = 1'b0;
        pop_word_o = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    n.addr    = start_addr_i;
                    n.bytes   = '0;
                    n.pkt_end = 1'b0;
                    n.state   = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                if (lvl_i != '0) begin
                    if ((q.addr[1:0] != 2'b00) || (eop_held_i && (lvl_i < LVL_W'(4)))) begin
                        n.size  = SZ_BYTE;
                        n.len   = LEN_W'(1);
                        n.beats = LEN_W'(1);
                        n.state = ST_ISSUE;
                    end else if (eop_held_i) begin
                        n.size  = SZ_WORD;
                        n.len   = tail_len;
                        n.beats = tail_len;
                        n.state = ST_ISSUE;
                    end else if (lvl_i >= HALF_BYTES) begin
                        n.size  = SZ_WORD;
                        n.len   = LEN_W'(HALF);
                        n.beats = LEN_W'(HALF);
                        n.state = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (ack_i) begin
                    if (q.size == SZ_WORD) begin
                        pop_word_o = 1'b1;
                        n.addr     = q.addr + ADDR_W'(4);
                        n.bytes    = q.bytes + CNT_W'(4);
                        n.pkt_end  = q.pkt_end | (|peek_last_i);
                    end else begin
                        pop_byte_o = 1'b1;
                        n.addr     = q.addr + ADDR_W'(1);
                        n.bytes    = q.bytes + CNT_W'(1);
                        n.pkt_end  = q.pkt_end | peek_last_i[0];
                    end
                    n.beats = q.beats - LEN_W'(1);
                    if (q.beats == LEN_W'(1)) begin
                        n.state = n.pkt_end ? ST_DONE : ST_DECIDE;
                    end
                end
            end
            default: begin
                n.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign req_o        = (q.state == ST_ISSUE);
    assign addr_o       = q.addr;
    assign size_o       = q.size;
    assign len_o        = q.len;
    assign done_o       = (q.state == ST_DONE);
    assign done_bytes_o = q.bytes;

    // R1: a burst begun before the packet end follows a level at the threshold
    p_threshold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_o) && (size_o == SZ_WORD) && !eop_held_i) |-> ($past(lvl_i) >= HALF_BYTES));

    // R2: word bursts carry between one and half-depth beats
    p_word_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && (size_o == SZ_WORD)) |-> ((len_o != '0) && (len_o <= LEN_W'(HALF))));

    // R3: a short word burst only occurs once the packet end is stored
    p_short_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && (size_o == SZ_WORD) && (len_o < LEN_W'(HALF))) |-> eop_held_i);

    // R4: word bursts are word-aligned
    p_word_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && (size_o == SZ_WORD)) |-> (addr_o[1:0] == 2'b00));

    // R5: byte accesses are single-beat
    p_byte_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && (size_o == SZ_BYTE)) |-> (len_o == LEN_W'(1)));

    // R6: address advances by the beat size inside an access
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i && (q.beats != LEN_W'(1))) |=>
        (addr_o == $past(addr_o) + ((size_o == SZ_WORD) ? ADDR_W'(4) : ADDR_W'(1))));

    // R8: request drops after the final acknowledged beat
    p_req_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i && (q.beats == LEN_W'(1))) |=> !req_o);

    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/rxdma_burst_writer.sv
module rxdma_burst_writer #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned FIFO_WORDS = 8,
    localparam int unsigned DEPTH = FIFO_WORDS * 4,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1),
    localparam int unsigned HALF  = FIFO_WORDS / 2,
    localparam int unsigned LEN_W = $clog2(HALF + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [1:0]        wr_size,
    output logic [LEN_W-1:0]  wr_len,
    output logic [31:0]       wr_data,
    input  logic              wr_ack,
    output logic              done,
    output logic [CNT_W-1:0]  done_bytes
);

    logic [LVL_W-1:0] level;
    logic             eop_held;
    logic [31:0]      peek_data;
    logic [3:0]       peek_last;
    logic             pop_byte;
    logic             pop_word;

    rxdma_byte_fifo #(.FIFO_WORDS(FIFO_WORDS)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid),
        .in_data_i   (in_data),
        .in_last_i   (in_last),
        .in_ready_o  (in_ready),
        .pop_byte_i  (pop_byte),
        .pop_word_i  (pop_word),
        .level_o     (level),
        .eop_held_o  (eop_held),
        .peek_data_o (peek_data),
        .peek_last_o (peek_last)
    );

    rxdma_xfer_ctrl #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .FIFO_WORDS (FIFO_WORDS)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .start_addr_i (start_addr),
        .ack_i        (wr_ack),
        .lvl_i        (level),
        .eop_held_i   (eop_held),
        .peek_last_i  (peek_last),
        .pop_byte_o   (pop_byte),
        .pop_word_o   (pop_word),
        .req_o        (wr_req),
        .addr_o       (wr_addr),
        .size_o       (wr_size),
        .len_o        (wr_len),
        .done_o       (done),
        .done_bytes_o (done_bytes)
    );

    rxdma_lane_pack u_pack (
        .peek_data_i (peek_data),
        .size_i      (wr_size),
        .lane_i      (wr_addr[1:0]),
        .data_o      (wr_data)
    );

endmodule

// File: tb/tb_rxdma_burst_writer.sv
`timescale 1ns/1ps
module tb_rxdma_burst_writer;

    localparam int FW    = 8;
    localparam int DEP   = FW * 4;
    localparam int HALFW = FW / 2;
    localparam int WD    = 20000;

    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0;
    logic [7:0] in_data = 0;
    logic in_last = 0;
    logic in_ready;
    logic start = 0;
    logic [31:0] start_addr = 0;
    logic wr_req;
    logic [31:0] wr_addr;
    logic [1:0] wr_size;
    logic [2:0] wr_len;
    logic [31:0] wr_data;
    logic wr_ack = 0;
    logic done;
    logic [15:0] done_bytes;

    rxdma_burst_writer #(.ADDR_W(32), .CNT_W(16), .FIFO_WORDS(FW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .start(start), .start_addr(start_addr),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_size(wr_size), .wr_len(wr_len),
        .wr_data(wr_data), .wr_ack(wr_ack), .done(done), .done_bytes(done_bytes)
    );

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    int ack_mode = 0;
    int cyc = 0;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int mq[$];
    int m_st = 0;
    longint m_addr = 0;
    int m_bytes = 0, m_size = 0, m_len = 0, m_beats = 0;
    bit m_end = 0, m_held = 0;

    always @(posedge clk) begin
        int lvl;
        bit rdy;
        if (!rst_n) begin
            mq.delete();
            m_st = 0; m_addr = 0; m_bytes = 0; m_size = 0; m_len = 0;
            m_beats = 0; m_end = 0; m_held = 0;
        end else begin
            lvl = mq.size();
            rdy = (lvl < DEP) && !m_held;
            case (m_st)
                0: if (start) begin
                    m_addr = start_addr; m_bytes = 0; m_end = 0; m_st = 1;
                end
                1: if (lvl > 0) begin
                    if ((m_addr % 4) != 0 || (m_held && lvl < 4)) begin
                        m_size = 0; m_len = 1; m_beats = 1; m_st = 2;
                    end else if (m_held) begin
                        m_size = 2; m_len = (lvl / 4 > HALFW) ? HALFW : lvl / 4;
                        m_beats = m_len; m_st = 2;
                    end else if (lvl >= HALFW * 4) begin
                        m_size = 2; m_len = HALFW; m_beats = HALFW; m_st = 2;
                    end
                end
                2: if (wr_ack) begin
                    for (int k = 0; k < ((m_size == 2) ? 4 : 1); k++) begin
                        int e;
                        e = mq.pop_front();
                        if (e[8]) begin m_end = 1; m_held = 0; end
                    end
                    m_addr = (m_addr + ((m_size == 2) ? 4 : 1)) & 32'hffffffff;
                    m_bytes += (m_size == 2) ? 4 : 1;
                    m_beats--;
                    if (m_beats == 0) m_st = m_end ? 3 : 1;
                end
                default: m_st = 0;
            endcase
            if (in_valid && rdy) begin
                mq.push_back({23'd0, in_last, in_data});
                if (in_last) m_held = 1;
            end
        end
    end

    // ---------------- compare and access monitor ----------------
    longint acc_addr[$];
    int acc_size[$];
    int acc_len[$];
    bit prev_req = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            chk(wr_req == (m_st == 2), "R8", "request line", wr_req, m_st == 2);
            chk(in_ready == ((mq.size() < DEP) && !m_held), "R10", "in_ready",
                in_ready, (mq.size() < DEP) && !m_held);
            chk(done == (m_st == 3), "R9", "done", done, m_st == 3);
            if (done && m_st == 3)
                chk(done_bytes == m_bytes, "R9", "done_bytes", done_bytes, m_bytes);
            if (wr_req && m_st == 2) begin
                longint exp_d;
                chk(wr_addr == m_addr, "R6", "beat address", wr_addr, m_addr);
                chk(wr_size == m_size && wr_len == m_len, "R2", "size/len",
                    {wr_size, 4'd0, wr_len}, {m_size[1:0], 4'd0, m_len[2:0]});
                if (m_size == 2)
                    exp_d = (mq[0] & 255) | ((mq[1] & 255) << 8) |
                            ((mq[2] & 255) << 16) | ((mq[3] & 255) << 24);
                else
                    exp_d = (mq[0] & 255) << (8 * (m_addr % 4));
                chk(wr_data == exp_d, "R7", "beat data", wr_data, exp_d);
            end
            if (wr_req && !prev_req) begin
                acc_addr.push_back(wr_addr);
                acc_size.push_back(wr_size);
                acc_len.push_back(wr_len);
            end
            prev_req = wr_req;
        end
    end

    always @(negedge clk) begin
        case (ack_mode)
            0: wr_ack <= 1'b1;
            1: wr_ack <= (cyc % 3) != 0;
            default: wr_ack <= (cyc % 5) == 1;
        endcase
    end

    // ---------------- stimulus ----------------
    function automatic logic [7:0] pbyte(int pk, int i);
        return 8'((pk * 37 + i * 13 + 5) & 255);
    endfunction

    task automatic feed(int pk, int len, int pause_at, bit slow);
        int i = 0;
        int t = 0;
        while (i < len) begin
            @(negedge clk);
            t++;
            if (pause_at > 0 && i == pause_at) begin
                in_valid = 0;
                repeat (20) @(negedge clk);
                // R1: level one byte below threshold, no burst may start
                chk(acc_addr.size() == 0, "R1", "accesses before threshold", acc_addr.size(), 0);
                pause_at = 0;
            end
            if (in_ready && (!slow || (t % 3) == 0)) begin
                in_valid = 1; in_data = pbyte(pk, i); in_last = (i == len - 1); i++;
            end else begin
                in_valid = 0;
            end
        end
        @(negedge clk);
        in_valid = 0; in_last = 0;
    endtask

    task automatic run_pkt(int pk, longint a0, int len, int pause_at, bit slow, int am, bit busy_start);
        int h = 0, tl = 0, wsum = 0, nwb = 0, bad_full = 0, last_w = 0;
        int head_exp, tail_exp;
        longint head_lim;
        bit got_done = 0;
        int got_bytes = 0;
        acc_addr.delete(); acc_size.delete(); acc_len.delete();
        ack_mode = am;
        fork
            feed(pk, len, pause_at, slow);
            begin
                @(negedge clk); start = 1; start_addr = 32'(a0);
                @(negedge clk); start = 0;
                if (busy_start) begin
                    repeat (3) @(negedge clk);
                    start = 1; start_addr = 32'(a0 ^ 32'h100);
                    @(negedge clk); start = 0;
                end
            end
        join
        while (!got_done) begin
            @(negedge clk);
            if (done) begin got_done = 1; got_bytes = done_bytes; end
        end
        chk(got_bytes == len, "R9", "packet byte total", got_bytes, len);
        if (busy_start)
            chk(acc_addr.size() > 0 && acc_addr[0] == a0, "R10", "start while busy ignored",
                acc_addr.size() > 0 ? acc_addr[0] : -1, a0);
        head_exp = (4 - (a0 % 4)) % 4;
        if (head_exp > len) head_exp = len;
        tail_exp = (len - head_exp) % 4;
        head_lim = a0 + ((4 - (a0 % 4)) % 4);
        foreach (acc_size[k]) begin
            if (acc_size[k] == 0) begin
                if (acc_addr[k] < head_lim) h++; else tl++;
            end else begin
                if (nwb > 0 && last_w != HALFW) bad_full++;
                wsum += acc_len[k]; last_w = acc_len[k]; nwb++;
            end
        end
        chk(h == head_exp, "R4", "head byte writes", h, head_exp);
        chk(tl == tail_exp, "R5", "tail byte writes", tl, tail_exp);
        chk(bad_full == 0, "R2", "non-final bursts not full", bad_full, 0);
        chk(wsum * 4 == len - head_exp - tail_exp && last_w <= HALFW, "R3",
            "word burst bytes", wsum * 4, len - head_exp - tail_exp);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        chk(0, "R9", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(wr_req == 0, "R10", "reset request line", wr_req, 0);
        chk(done == 0, "R10", "reset done", done, 0);
        chk(in_ready == 1, "R10", "reset in_ready", in_ready, 1);
        run_pkt(1, 32'h1000, 40, 0, 0, 0, 0);
        run_pkt(2, 32'h2001, 37, 0, 0, 1, 1);
        run_pkt(3, 32'h3003, 2, 0, 0, 0, 0);
        run_pkt(4, 32'h4000, 35, 15, 0, 0, 0);
        run_pkt(5, 32'h5002, 70, 0, 1, 2, 0);
        run_pkt(6, 32'h6000, 4, 0, 0, 1, 0);
        run_pkt(7, 32'h7001, 3, 0, 0, 0, 0);
        summary();
    end

endmodule